// File: doc/BRIEF.md
# Video Source Selector with Component Clipper

This block sits in a video output path between a streamed pixel source and the output formatter. On every cycle where the data-enable input is high it picks one of four pixel sources: blank, the incoming stream, a generated horizontal ramp, or a programmable solid color. It then limits each 8-bit color component of the picked pixel to a programmable lower and upper bound, so the output can be switched between full-range and limited-range coding at run time by rewriting two registers.

The result leaves through one register stage, with the output data-enable delayed by the same cycle. A small word-addressed register port sets the source, the solid color, the bounds and a control word. The control word's bits are not used inside the block but are exported to the colour-conversion and subsampling stages downstream. A status word collects sticky error flags. One flag is raised by the block itself when the stream starves; the other four come from event inputs driven by neighbouring blocks. Software clears the flags by writing ones to them.

Top module: `vid_src_clip`

## Requirements
- R1: After reset, out_de and out_data are 0, the control, source, solid-color, lower-bound and status registers read 0, the upper-bound register reads 0xFFFFFF, and the three control outputs are 0.
- R2: Registers sit at word addresses 0 control (bits 2:0), 1 source (bits 1:0), 2 solid color (bits 24:0), 3 upper bound (bits 23:0), 4 lower bound (bits 23:0) and 5 status (bits 4:0). A read returns the stored value with every unimplemented bit at 0. Addresses 6 and 7 read as 0, and writes to them change no register.
- R3: out_de equals pix_de one cycle earlier, and out_data is 0 on every cycle where out_de is 0. A register write affects pixels from the next cycle on.
- R4: Source code 0 (blank) feeds a zero pixel into the clipper, so the output equals the lower bound.
- R5: Source code 1 (stream) passes pix_data through the clipper when pix_valid is high.
- R6: Source code 2 (ramp) sets all three components to the low 8 bits of a pixel counter. The counter is 0 on the first data-enable cycle after a cycle with pix_de low, rises by one on each data-enable cycle, and wraps past 255 in the output byte.
- R7: Source code 3 (solid) outputs bits 23:0 of the solid-color register, clipped. Bit 24 of that register is stored and read back but does not affect pixels.
- R8: Each 8-bit component c, in bits [8k+7:8k] for k = 0..2, is first limited to at most its upper bound, then raised to at least its lower bound. When the lower bound exceeds the upper bound, the output is the lower bound.
- R9: With bounds 0x101010 and 0xF0EBF0 (limited range), the middle component saturates at 0xEB while the outer two saturate at 0xF0, and no component falls below 0x10.
- R10: A data-enable cycle in stream mode with pix_valid low sets status bit 4 and feeds a zero pixel into the clipper.
- R11: A high err_ovf, err_bus, err_in_sync or err_out_sync sets status bit 3, 2, 1 or 0 respectively at the next clock edge. A set bit stays set.
- R12: Writing a 1 to a status bit clears it, and writing a 0 leaves it alone. An event in the same cycle as the clearing write wins, so the bit stays set.
- R13: Control bits 0, 1 and 2 appear on csc_bypass, full_range and subsamp_bypass respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 25 | Register write data |
| cfg_rdata | output | 25 | Register read data (combinational from cfg_addr) |
| pix_de | input | 1 | Data-enable of the current pixel slot |
| pix_valid | input | 1 | Stream pixel present |
| pix_data | input | 24 | Stream pixel, three 8-bit components |
| err_ovf | input | 1 | Overflow event from upstream |
| err_bus | input | 1 | Bus error event from upstream |
| err_in_sync | input | 1 | Input-side timing lost sync |
| err_out_sync | input | 1 | Output-side timing lost sync |
| out_de | output | 1 | Delayed data-enable |
| out_data | output | 24 | Selected and clipped pixel |
| csc_bypass | output | 1 | Exported control bit 0 |
| full_range | output | 1 | Exported control bit 1 |
| subsamp_bypass | output | 1 | Exported control bit 2 |

## Verification
On every cycle the assertions check the one-cycle data-enable delay and the zero data outside data-enable. For each component they check that the output lies between the bounds in force one cycle earlier, or equals the lower bound when the bounds are inverted. They also check that status bits only drop under a clearing write and that a starved stream cycle raises the underflow flag. Only the bench's scenarios can show the exact pixel values:
- the ramp restarting and wrapping,
- the solid color ignoring its flag bit,
- the limited-range saturation values,
- the register map with its unused addresses,
- the precedence of a new event over a clearing write.

// File: rtl/vsc_pkg.sv
package vsc_pkg;

  typedef enum logic [1:0] {
    SRC_BLANK  = 2'd0,
    SRC_STREAM = 2'd1,
    SRC_RAMP   = 2'd2,
    SRC_SOLID  = 2'd3
  } src_sel_e;

  localparam int ADDR_W = 3;
  localparam int CTRL_W = 3;
  localparam int N_STAT = 5;
  localparam int ST_UNDER = 4;

  localparam logic [ADDR_W-1:0] RA_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] RA_SRC   = 3'd1;
  localparam logic [ADDR_W-1:0] RA_SOLID = 3'd2;
  localparam logic [ADDR_W-1:0] RA_HI    = 3'd3;
  localparam logic [ADDR_W-1:0] RA_LO    = 3'd4;
  localparam logic [ADDR_W-1:0] RA_STAT  = 3'd5;

endpackage

// File: rtl/vsc_regs.sv
module vsc_regs
  import vsc_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int REG_W = 25
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [REG_W-1:0]    wdata,
  input  logic [N_STAT-1:0]   ev,
  output logic [REG_W-1:0]    rdata,
  output logic [CTRL_W-1:0]   ctrl,
  output src_sel_e            src,
  output logic [PIX_W-1:0]    solid,
  output logic [PIX_W-1:0]    hi,
  output logic [PIX_W-1:0]    lo,
  output logic [N_STAT-1:0]   stat
);

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  src_sel_e          src_q, src_d;
  logic [REG_W-1:0]  solid_q, solid_d;
  logic [PIX_W-1:0]  hi_q, hi_d;
  logic [PIX_W-1:0]  lo_q, lo_d;
  logic [N_STAT-1:0] stat_q, stat_d;
  logic [N_STAT-1:0] clr;
  logic en_ctrl, en_src, en_solid, en_hi, en_lo;

  always_comb begin
    en_ctrl  = we && (addr == RA_CTRL);
    en_src   = we && (addr == RA_SRC);
    en_solid = we && (addr == RA_SOLID);
    en_hi    = we && (addr == RA_HI);
    en_lo    = we && (addr == RA_LO);
    ctrl_d   = wdata[CTRL_W-1:0];
    src_d    = src_sel_e'(wdata[1:0]);
    solid_d  = wdata;
    hi_d     = wdata[PIX_W-1:0];
    lo_d     = wdata[PIX_W-1:0];
    clr      = (we && (addr == RA_STAT)) ? wdata[N_STAT-1:0] : '0;
    stat_d   = (stat_q & ~clr) | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      src_q   <= SRC_BLANK;
      solid_q <= '0;
      hi_q    <= '1;
      lo_q    <= '0;
      stat_q  <= '0;
    end else begin
      if (en_ctrl)  ctrl_q  <= ctrl_d;
      if (en_src)   src_q   <= src_d;
      if (en_solid) solid_q <= solid_d;
      if (en_hi)    hi_q    <= hi_d;
      if (en_lo)    lo_q    <= lo_d;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_CTRL:  rdata[CTRL_W-1:0] = ctrl_q;
      RA_SRC:   rdata[1:0]        = src_q;
      RA_SOLID: rdata             = solid_q;
      RA_HI:    rdata[PIX_W-1:0]  = hi_q;
      RA_LO:    rdata[PIX_W-1:0]  = lo_q;
      RA_STAT:  rdata[N_STAT-1:0] = stat_q;
      default:  rdata             = '0;
    endcase
  end

  assign ctrl  = ctrl_q;
  assign src   = src_q;
  assign solid = solid_q[PIX_W-1:0];
  assign hi    = hi_q;
  assign lo    = lo_q;
  assign stat  = stat_q;

endmodule

// File: rtl/vsc_xcount.sv
module vsc_xcount #(
  parameter int XCNT_W = 12,
  parameter int OUT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             de,
  output logic [OUT_W-1:0] x
);

  logic [XCNT_W-1:0] x_q, x_d;

  always_comb begin
    x_d = de ? (x_q + XCNT_W'(1)) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) x_q <= '0;
    else        x_q <= x_d;
  end

  assign x = x_q[OUT_W-1:0];

endmodule

// File: rtl/vsc_clamp.sv
module vsc_clamp #(
  parameter int COMP_W = 8
) (
  input  logic [COMP_W-1:0] c,
  input  logic [COMP_W-1:0] lo,
  input  logic [COMP_W-1:0] hi,
  output logic [COMP_W-1:0] y
);

  logic [COMP_W-1:0] capped;

  always_comb begin
    capped = (c > hi) ? hi : c;
    y      = (capped < lo) ? lo : capped;
  end

endmodule

// File: rtl/vsc_pix.sv
module vsc_pix
  import vsc_pkg::*;
#(
  parameter int COMP_W = 8,
  parameter int NCOMP  = 3,
  parameter int PIX_W  = COMP_W * NCOMP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              de,
  input  logic              valid,
  input  logic [PIX_W-1:0]  din,
  input  src_sel_e          src,
  input  logic [PIX_W-1:0]  solid,
  input  logic [COMP_W-1:0] ramp,
  input  logic [PIX_W-1:0]  lo,
  input  logic [PIX_W-1:0]  hi,
  output logic              underflow,
  output logic              out_de,
  output logic [PIX_W-1:0]  out_data
);

  logic [PIX_W-1:0] raw, clip, pix_d, pix_q;
  logic             de_q;

  always_comb begin
    case (src)
      SRC_BLANK:  raw = '0;
      SRC_STREAM: raw = valid ? din : '0;
      SRC_RAMP:   raw = {NCOMP{ramp}};
      SRC_SOLID:  raw = solid;
      default:    raw = '0;
    endcase
    underflow = de && (src == SRC_STREAM) && !valid;
  end

  for (genvar k = 0; k < NCOMP; k++) begin : g_lane
    vsc_clamp #(.COMP_W(COMP_W)) u_clamp (
      .c  (raw[k*COMP_W +: COMP_W]),
      .lo (lo[k*COMP_W +: COMP_W]),
      .hi (hi[k*COMP_W +: COMP_W]),
      .y  (clip[k*COMP_W +: COMP_W])
    );
  end

  always_comb begin
    pix_d = de ? clip : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q  <= 1'b0;
      pix_q <= '0;
    end else begin
      de_q  <= de;
      pix_q <= pix_d;
    end
  end

  assign out_de   = de_q;
  assign out_data = pix_q;

endmodule

// File: rtl/vid_src_clip.sv
module vid_src_clip
  import vsc_pkg::*;
#(
  parameter int COMP_W = 8,
  parameter int NCOMP  = 3,
  parameter int XCNT_W = 12,
  localparam int PIX_W = COMP_W * NCOMP,
  localparam int REG_W = PIX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              pix_de,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic              err_ovf,
  input  logic              err_bus,
  input  logic              err_in_sync,
  input  logic              err_out_sync,
  output logic              out_de,
  output logic [PIX_W-1:0]  out_data,
  output logic              csc_bypass,
  output logic              full_range,
  output logic              subsamp_bypass
);

  logic [CTRL_W-1:0] ctrl_w;
  src_sel_e          src_w;
  logic [PIX_W-1:0]  solid_w, hi_w, lo_w;
  logic [N_STAT-1:0] stat_w, ev_w;
  logic [COMP_W-1:0] ramp_w;
  logic              under_w;

  assign ev_w = {under_w, err_ovf, err_bus, err_in_sync, err_out_sync};

  vsc_regs #(.PIX_W(PIX_W), .REG_W(REG_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .ev    (ev_w),
    .rdata (cfg_rdata),
    .ctrl  (ctrl_w),
    .src   (src_w),
    .solid (solid_w),
    .hi    (hi_w),
    .lo    (lo_w),
    .stat  (stat_w)
  );

  vsc_xcount #(.XCNT_W(XCNT_W), .OUT_W(COMP_W)) u_xcnt (
    .clk   (clk),
    .rst_n (rst_n),
    .de    (pix_de),
    .x     (ramp_w)
  );

  vsc_pix #(.COMP_W(COMP_W), .NCOMP(NCOMP)) u_pix (
    .clk       (clk),
    .rst_n     (rst_n),
    .de        (pix_de),
    .valid     (pix_valid),
    .din       (pix_data),
    .src       (src_w),
    .solid     (solid_w),
    .ramp      (ramp_w),
    .lo        (lo_w),
    .hi        (hi_w),
    .underflow (under_w),
    .out_de    (out_de),
    .out_data  (out_data)
  );

  assign csc_bypass     = ctrl_w[0];
  assign full_range     = ctrl_w[1];
  assign subsamp_bypass = ctrl_w[2];

endmodule

// File: rtl/vsc_src_clip_chk.sv
module vsc_src_clip_chk
  import vsc_pkg::*;
#(
  parameter int COMP_W = 8,
  parameter int NCOMP  = 3,
  parameter int PIX_W  = COMP_W * NCOMP
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [N_STAT-1:0] cfg_wdata,
  input logic              pix_de,
  input logic              pix_valid,
  input logic              out_de,
  input logic [PIX_W-1:0]  out_data,
  input logic [1:0]        src,
  input logic [PIX_W-1:0]  lo,
  input logic [PIX_W-1:0]  hi,
  input logic [N_STAT-1:0] stat
);

  logic [N_STAT-1:0] clr_mask;

  always_comb begin
    clr_mask = (cfg_we && (cfg_addr == RA_STAT)) ? cfg_wdata : '0;
  end

  AST_DE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_de == $past(pix_de)); // R3

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !out_de |-> (out_data == '0)); // R3

  AST_UNDERFLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pix_de && !pix_valid && (src == SRC_STREAM)) |-> stat[ST_UNDER]); // R10

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(stat) & ~$past(clr_mask)) & ~stat) == '0); // R12

  for (genvar k = 0; k < NCOMP; k++) begin : g_lane
    AST_LANE_IN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_de && $past(lo[k*COMP_W +: COMP_W] <= hi[k*COMP_W +: COMP_W])) |->
      ((out_data[k*COMP_W +: COMP_W] >= $past(lo[k*COMP_W +: COMP_W])) &&
       (out_data[k*COMP_W +: COMP_W] <= $past(hi[k*COMP_W +: COMP_W])))); // R8

    AST_LOW_BOUND_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_de && $past(lo[k*COMP_W +: COMP_W] > hi[k*COMP_W +: COMP_W])) |->
      (out_data[k*COMP_W +: COMP_W] == $past(lo[k*COMP_W +: COMP_W]))); // R8
  end

endmodule

bind vid_src_clip vsc_src_clip_chk #(.COMP_W(COMP_W), .NCOMP(NCOMP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata[vsc_pkg::N_STAT-1:0]),
  .pix_de    (pix_de),
  .pix_valid (pix_valid),
  .out_de    (out_de),
  .out_data  (out_data),
  .src       (src_w),
  .lo        (lo_w),
  .hi        (hi_w),
  .stat      (stat_w)
);

// File: tb/vid_src_clip_test.sv
module vid_src_clip_test;

  localparam int PW = 24;
  localparam int RW = 25;

  logic          clk;
  logic          rst_n;
  logic          cfg_we;
  logic [2:0]    cfg_addr;
  logic [RW-1:0] cfg_wdata;
  logic [RW-1:0] cfg_rdata;
  logic          pix_de, pix_valid;
  logic [PW-1:0] pix_data;
  logic          err_ovf, err_bus, err_in_sync, err_out_sync;
  logic          out_de;
  logic [PW-1:0] out_data;
  logic          csc_bypass, full_range, subsamp_bypass;

  int n_chk;
  int n_fail;

  logic [2:0]    m_ctrl;
  logic [1:0]    m_src;
  logic [RW-1:0] m_solid;
  logic [PW-1:0] m_hi, m_lo;
  logic [4:0]    m_stat;
  logic [11:0]   m_x;

  vid_src_clip uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_we         (cfg_we),
    .cfg_addr       (cfg_addr),
    .cfg_wdata      (cfg_wdata),
    .cfg_rdata      (cfg_rdata),
    .pix_de         (pix_de),
    .pix_valid      (pix_valid),
    .pix_data       (pix_data),
    .err_ovf        (err_ovf),
    .err_bus        (err_bus),
    .err_in_sync    (err_in_sync),
    .err_out_sync   (err_out_sync),
    .out_de         (out_de),
    .out_data       (out_data),
    .csc_bypass     (csc_bypass),
    .full_range     (full_range),
    .subsamp_bypass (subsamp_bypass)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] lim(input logic [7:0] c, input logic [7:0] lo,
                                     input logic [7:0] hi);
    logic [7:0] t;
    t = (c > hi) ? hi : c;
    return (t < lo) ? lo : t;
  endfunction

  function automatic logic [PW-1:0] model_pix(input logic vld, input logic [PW-1:0] d);
    logic [PW-1:0] raw, res;
    case (m_src)
      2'd0: raw = '0;
      2'd1: raw = vld ? d : '0;
      2'd2: raw = {3{m_x[7:0]}};
      default: raw = m_solid[PW-1:0];
    endcase
    for (int k = 0; k < 3; k++)
      res[k*8 +: 8] = lim(raw[k*8 +: 8], m_lo[k*8 +: 8], m_hi[k*8 +: 8]);
    return res;
  endfunction

  task automatic cyc(input logic de, input logic vld, input logic [PW-1:0] d,
                     input logic we, input logic [2:0] a, input logic [RW-1:0] wd,
                     input logic [3:0] ev, input string tag);
    logic          e_de;
    logic [PW-1:0] e_px;
    logic [4:0]    clr;
    string         t;
    pix_de = de; pix_valid = vld; pix_data = d;
    cfg_we = we; cfg_addr = a; cfg_wdata = wd;
    err_ovf = ev[3]; err_bus = ev[2]; err_in_sync = ev[1]; err_out_sync = ev[0];
    e_de = de;
    e_px = de ? model_pix(vld, d) : '0;
    t = tag;
    if (t == "") begin
      if (!de) t = "R3";
      else case (m_src)
        2'd0: t = "R4";
        2'd1: t = "R5";
        2'd2: t = "R6";
        default: t = "R7";
      endcase
    end
    clr = (we && a == 3'd5) ? wd[4:0] : 5'd0;
    m_stat = (m_stat & ~clr) | {de && (m_src == 2'd1) && !vld, ev};
    m_x = de ? m_x + 12'd1 : 12'd0;
    if (we) begin
      case (a)
        3'd0: m_ctrl  = wd[2:0];
        3'd1: m_src   = wd[1:0];
        3'd2: m_solid = wd;
        3'd3: m_hi    = wd[PW-1:0];
        3'd4: m_lo    = wd[PW-1:0];
        default: ;
      endcase
    end
    @(negedge clk);
    chk("R3", "out_de", 32'(out_de), 32'(e_de));
    chk(t, "out_data", 32'(out_data), 32'(e_px));
  endtask

  task automatic wr(input logic [2:0] a, input logic [RW-1:0] wd);
    cyc(1'b0, 1'b0, '0, 1'b1, a, wd, 4'd0, "");
  endtask

  task automatic px(input logic de, input logic vld, input logic [PW-1:0] d,
                    input string tag);
    cyc(de, vld, d, 1'b0, 3'd0, '0, 4'd0, tag);
  endtask

  task automatic rd(input logic [2:0] a, input logic [RW-1:0] exp, input string tag);
    cfg_we = 1'b0;
    cfg_addr = a;
    #1;
    chk(tag, "rdata", 32'(cfg_rdata), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [31:0] r;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    pix_de = 1'b0; pix_valid = 1'b0; pix_data = '0;
    err_ovf = 1'b0; err_bus = 1'b0; err_in_sync = 1'b0; err_out_sync = 1'b0;
    m_ctrl = '0; m_src = '0; m_solid = '0; m_hi = 24'hFFFFFF; m_lo = '0;
    m_stat = '0; m_x = '0;

    // R1: state in and just after reset
    repeat (3) @(negedge clk);
    chk("R1", "out_de", 32'(out_de), 32'd0);
    chk("R1", "out_data", 32'(out_data), 32'd0);
    rst_n = 1'b1;
    rd(3'd0, 25'd0, "R1");
    rd(3'd1, 25'd0, "R1");
    rd(3'd2, 25'd0, "R1");
    rd(3'd3, 25'hFFFFFF, "R1");
    rd(3'd4, 25'd0, "R1");
    rd(3'd5, 25'd0, "R1");
    chk("R1", "ctrl outs", 32'({csc_bypass, full_range, subsamp_bypass}), 32'd0);

    // R2: register map and masking
    wr(3'd0, '1); rd(3'd0, 25'h7, "R2");
    wr(3'd1, '1); rd(3'd1, 25'h3, "R2");
    wr(3'd2, '1); rd(3'd2, 25'h1FFFFFF, "R2");
    wr(3'd3, 25'h1ABCDEF); rd(3'd3, 25'hABCDEF, "R2");
    wr(3'd4, 25'h1123456); rd(3'd4, 25'h123456, "R2");
    wr(3'd6, '1); wr(3'd7, '1);
    rd(3'd6, 25'd0, "R2");
    rd(3'd7, 25'd0, "R2");
    rd(3'd0, 25'h7, "R2");
    rd(3'd3, 25'hABCDEF, "R2");

    // R13: exported control bits
    wr(3'd0, 25'h5);
    chk("R13", "csc", 32'(csc_bypass), 32'd1);
    chk("R13", "full", 32'(full_range), 32'd0);
    chk("R13", "ss", 32'(subsamp_bypass), 32'd1);
    wr(3'd0, 25'h2);
    chk("R13", "ctrl outs", 32'({subsamp_bypass, full_range, csc_bypass}), 32'h2);

    wr(3'd3, 25'hFFFFFF); wr(3'd4, 25'd0); wr(3'd1, 25'd0); wr(3'd2, 25'd0);

    // R4: blank source
    px(1'b1, 1'b1, 24'h123456, "R4");
    px(1'b1, 1'b1, 24'hFFFFFF, "R4");
    wr(3'd4, 25'h101010);
    px(1'b1, 1'b1, 24'hABCDEF, "R4");
    wr(3'd4, 25'd0);

    // R5: stream pass-through
    wr(3'd1, 25'd1);
    for (int i = 0; i < 20; i++) px(1'b1, 1'b1, 24'($urandom), "R5");

    // R6: ramp with wrap and restart
    wr(3'd1, 25'd2);
    for (int i = 0; i < 300; i++) px(1'b1, 1'b0, '0, "R6");
    px(1'b0, 1'b0, '0, "R6");
    for (int i = 0; i < 5; i++) px(1'b1, 1'b1, 24'($urandom), "R6");

    // R7: solid color, flag bit ignored
    wr(3'd1, 25'd3);
    wr(3'd2, 25'h13A5C7E);
    px(1'b1, 1'b1, 24'h000000, "R7");
    wr(3'd2, 25'h03A5C7E);
    px(1'b1, 1'b1, 24'hFFFFFF, "R7");
    rd(3'd2, 25'h03A5C7E, "R7");

    // R9: limited range bounds
    wr(3'd1, 25'd1);
    wr(3'd3, 25'hF0EBF0); wr(3'd4, 25'h101010);
    px(1'b1, 1'b1, 24'h00FF80, "R9");
    px(1'b1, 1'b1, 24'hFFFFFF, "R9");
    px(1'b1, 1'b1, 24'h000000, "R9");
    px(1'b1, 1'b1, 24'hF1EC0F, "R9");

    // R8: independent lanes and inverted bounds
    wr(3'd4, 25'h200040); wr(3'd3, 25'hC0FF50);
    for (int i = 0; i < 10; i++) px(1'b1, 1'b1, 24'($urandom), "R8");
    wr(3'd4, 25'h808080); wr(3'd3, 25'h404040);
    for (int i = 0; i < 5; i++) px(1'b1, 1'b1, 24'($urandom), "R8");
    wr(3'd3, 25'hFFFFFF); wr(3'd4, 25'd0);

    // R10: underflow in stream mode
    px(1'b1, 1'b0, 24'hFFFFFF, "R10");
    rd(3'd5, 25'h10, "R10");
    px(1'b1, 1'b1, 24'h55AA55, "R10");
    rd(3'd5, 25'h10, "R10");

    // R11: external events
    cyc(1'b0, 1'b0, '0, 1'b0, 3'd0, '0, 4'b1010, "R11");
    rd(3'd5, 25'h1A, "R11");
    cyc(1'b0, 1'b0, '0, 1'b0, 3'd0, '0, 4'b0101, "R11");
    rd(3'd5, 25'h1F, "R11");
    px(1'b0, 1'b0, '0, "R11");
    rd(3'd5, 25'h1F, "R11");

    // R12: write-one-to-clear, event wins
    wr(3'd5, 25'h08);
    rd(3'd5, 25'h17, "R12");
    cyc(1'b0, 1'b0, '0, 1'b1, 3'd5, 25'h01, 4'b0001, "R12");
    rd(3'd5, 25'h17, "R12");
    wr(3'd5, 25'h1F);
    rd(3'd5, 25'h00, "R12");

    // Constrained random mix
    for (int i = 0; i < 4000; i++) begin
      r = $urandom;
      cyc(r[0] | r[1], r[2] | r[3] | r[4], 24'($urandom),
          (r[9:5] == 5'd0), r[12:10], 25'($urandom),
          (r[16:13] == 4'd0) ? r[20:17] : 4'd0, "");
      if ((i % 64) == 63) begin
        rd(3'd5, 25'(m_stat), "R11");
        rd(3'd1, 25'(m_src), "R2");
        rd(3'd4, 25'(m_lo), "R2");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule